// File: doc/BRIEF.md
# Sleep-Triggered Clock Source Controller

This block decides what happens to the operating mode and to the system clock source when the processor issues a sleep request. It holds a small control register, written over a simple bus port. The register carries a clock-change enable and a PLL select. The block also reads several status pins: a standby enable, a low-speed-on flag, the present speed mode, a PLL lock indication and a wake event. From these it drives the present mode (active, sleep or standby/watch) and a registered one-hot select that tells an external clock multiplexer which source to use. The sources are the main clock, the PLL clock and the 32 kHz subclock.

A sleep request has one of three outcomes. If standby is not enabled, the chip only sleeps and the source stays as it is. If standby is enabled and clock change is off, the chip parks in standby. The chosen source is then held pending and is put in place on the wake edge. If standby is enabled and clock change is on, the source is switched at once and the chip stays active. The low-speed flag takes priority over the PLL select. A request for the PLL clock while the PLL is not locked changes nothing and raises a sticky fault flag.

The write port uses valid/ready. `wr_ready` is always high, so a write is taken on every clock edge where `wr_valid` is high, and there is never back-pressure. The mode and status pins are plain level or pulse signals.

Top module: `slp_clk_ctl`

## Requirements
- R1: After reset, `mode_o` is 0 (active), `clk_sel_o` is 3'b001 (main clock), `rd_data` is 0 and `pll_fault` is 0.
- R2: `wr_ready` is always 1. An edge with `wr_valid` high stores `wr_data`. The bits `rd_data[7:5]`, `rd_data[2]` (clock-change enable) and `rd_data[0]` (PLL select) read back what was written. The bits `rd_data[4]`, `rd_data[3]` and `rd_data[1]` ignore writes and always read 0.
- R3: Suppose `sleep_req` is high in active mode and `sby_en` is 0. One edge later `mode_o` is 1 (sleep) and `clk_sel_o` is unchanged.
- R4: Suppose `sleep_req` is high in active mode, `sby_en` is 1, clock-change enable is 0 and the speed mode is high or medium. One edge later `mode_o` is 2 (standby) and `clk_sel_o` is unchanged. On the edge that takes `wake`, `mode_o` returns to 0 and `clk_sel_o` takes the target source on that same edge.
- R5: Suppose `sleep_req` is high in active mode, `sby_en` is 1, clock-change enable is 1 and the speed mode is high or medium. One edge later `mode_o` is still 0 and `clk_sel_o` shows the target source.
- R6: The target source follows the PLL select: 0 selects main (3'b001) and 1 selects PLL (3'b010). If `lson` is 1, the target is the subclock (3'b100) whatever the PLL select is.
- R7: `speed_mode` codes are 0 for high, 1 for medium, and 2 or 3 for subactive. A sleep request with `sby_en` = 1 from subactive enters standby and changes no source, whatever the clock-change and PLL-select bits are.
- R8: A target of PLL while `pll_locked` is 0 leaves the source unchanged and sets `pll_fault` one edge later. The mode outcome stays as in R4 or R5, and nothing is left pending. `pll_fault` stays at 1 until an accepted write clears it one edge later. If a new fault arrives on the same edge as the write, the set wins.
- R9: `wake` in sleep or standby returns `mode_o` to 0 one edge later. `wake` in active mode has no effect. `sleep_req` is ignored outside active mode.
- R10: `clk_sel_o` is one-hot at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register contents, reserved bits read 0 |
| sleep_req | input | 1 | Sleep instruction executed (one-cycle pulse) |
| sby_en | input | 1 | Standby enable flag |
| lson | input | 1 | Low-speed-on flag, selects subclock |
| speed_mode | input | 2 | 0 high, 1 medium, 2/3 subactive |
| pll_locked | input | 1 | PLL running and stable |
| wake | input | 1 | Wake event |
| mode_o | output | 2 | 0 active, 1 sleep, 2 standby/watch |
| clk_sel_o | output | 3 | One-hot source: bit0 main, bit1 PLL, bit2 subclock |
| pll_fault | output | 1 | Sticky blocked-PLL-switch flag |

## Verification
Every result the block drives appears one edge after the stimulus that causes it. This holds for the mode change after a sleep request or wake, an immediate source switch, the fault set or clear, and the write read back. A deferred source appears on the same edge as the return to active. The driver applies each stimulus at a falling edge and waits one rising edge. It then queues the expected mode, select, fault and read-back values. The monitor pops and compares them at the next falling edge, when every registered output has settled. Holding cycles with no stimulus are queued as well, to prove that pending changes and the fault flag stay put.

// File: rtl/slp_clk_pkg.sv
package slp_clk_pkg;

  localparam int NSRC  = 3;
  localparam int SPD_W = 2;

  typedef enum logic [1:0] {
    MD_ACTIVE  = 2'd0,
    MD_SLEEP   = 2'd1,
    MD_STANDBY = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_PLL  = 2'd1,
    SRC_SUB  = 2'd2
  } src_e;

  localparam logic [SPD_W-1:0] SPD_HIGH = 2'd0;
  localparam logic [SPD_W-1:0] SPD_MED  = 2'd1;

  typedef struct packed {
    mode_e nxt_mode;
    logic  apply_now;
    logic  defer;
    src_e  tgt;
    logic  fault;
  } verdict_t;

endpackage

// File: rtl/slp_cfg_reg.sv
module slp_cfg_reg #(
  parameter int              REG_W     = 8,
  parameter logic [REG_W-1:0] KEEP_MASK = 8'hE5,
  parameter int              CCE_BIT   = 2,
  parameter int              PSEL_BIT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             cce,
  output logic             psel
);

  logic [REG_W-1:0] bits_q;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (KEEP_MASK[i]) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bits_q[i] <= 1'b0;
        else if (wr_fire) bits_q[i] <= wr_data[i];
      end
    end else begin : g_rsvd
      assign bits_q[i] = 1'b0;
    end
  end

  assign rd_data = bits_q;
  assign cce     = bits_q[CCE_BIT];
  assign psel    = bits_q[PSEL_BIT];

  AST_WR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (rd_data == ($past(wr_data) & KEEP_MASK))); // R2

endmodule

// File: rtl/slp_decide.sv
module slp_decide
  import slp_clk_pkg::*;
(
  input  logic             fire,
  input  logic             sby_en,
  input  logic             cce,
  input  logic             psel,
  input  logic             lson,
  input  logic [SPD_W-1:0] speed_mode,
  input  logic             pll_locked,
  input  src_e             cur_src,
  output verdict_t         verdict
);

  logic hsms;
  logic blocked;
  src_e want;

  assign hsms    = (speed_mode == SPD_HIGH) || (speed_mode == SPD_MED);
  assign want    = lson ? SRC_SUB : (psel ? SRC_PLL : SRC_MAIN);
  assign blocked = (want == SRC_PLL) && !pll_locked;

  always_comb begin
    verdict.nxt_mode  = MD_ACTIVE;
    verdict.apply_now = 1'b0;
    verdict.defer     = 1'b0;
    verdict.tgt       = cur_src;
    verdict.fault     = 1'b0;
    if (fire) begin
      if (!sby_en) begin
        verdict.nxt_mode = MD_SLEEP;
      end else if (!hsms) begin
        verdict.nxt_mode = MD_STANDBY;
      end else begin
        verdict.fault = blocked;
        verdict.tgt   = blocked ? cur_src : want;
        if (cce) begin
          verdict.nxt_mode  = MD_ACTIVE;
          verdict.apply_now = !blocked;
        end else begin
          verdict.nxt_mode = MD_STANDBY;
          verdict.defer    = !blocked;
        end
      end
    end
  end

  always_comb begin
    if (verdict.fault) assert (fire && !pll_locked); // R8
  end

endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_clk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sleep_req,
  input  logic     wake,
  input  logic     wr_fire,
  input  verdict_t verdict,
  output mode_e    mode,
  output src_e     cur_src,
  output logic     fault
);

  logic pend_vld;
  src_e pend_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MD_ACTIVE;
      cur_src  <= SRC_MAIN;
      pend_vld <= 1'b0;
      pend_src <= SRC_MAIN;
      fault    <= 1'b0;
    end else begin
      if (wr_fire)       fault <= 1'b0;
      if (verdict.fault) fault <= 1'b1;
      if (mode == MD_ACTIVE) begin
        if (sleep_req) begin
          mode <= verdict.nxt_mode;
          if (verdict.apply_now) cur_src <= verdict.tgt;
          if (verdict.defer) begin
            pend_vld <= 1'b1;
            pend_src <= verdict.tgt;
          end
        end
      end else if (wake) begin
        mode     <= MD_ACTIVE;
        pend_vld <= 1'b0;
        if (pend_vld) cur_src <= pend_src;
      end
    end
  end

  AST_PARKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_ACTIVE && !wake) |=> (mode == $past(mode) && $stable(cur_src))); // R9

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !wr_fire) |=> fault); // R8

  AST_DIRECT_STAYS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_ACTIVE && sleep_req && verdict.apply_now) |=> (mode == MD_ACTIVE)); // R5

  AST_WAKE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_ACTIVE && wake) |=> (mode == MD_ACTIVE)); // R9

endmodule

// File: rtl/slp_clk_ctl.sv
module slp_clk_ctl
  import slp_clk_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             sleep_req,
  input  logic             sby_en,
  input  logic             lson,
  input  logic [SPD_W-1:0] speed_mode,
  input  logic             pll_locked,
  input  logic             wake,
  output logic [1:0]       mode_o,
  output logic [NSRC-1:0]  clk_sel_o,
  output logic             pll_fault
);

  logic     wr_fire;
  logic     cce;
  logic     psel;
  logic     fire;
  mode_e    mode;
  src_e     cur_src;
  verdict_t verdict;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;
  assign fire     = sleep_req && (mode == MD_ACTIVE);

  slp_cfg_reg #(.REG_W(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_data(wr_data),
    .rd_data(rd_data), .cce(cce), .psel(psel)
  );

  slp_decide u_dec (
    .fire(fire), .sby_en(sby_en), .cce(cce), .psel(psel), .lson(lson),
    .speed_mode(speed_mode), .pll_locked(pll_locked), .cur_src(cur_src),
    .verdict(verdict)
  );

  slp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake(wake),
    .wr_fire(wr_fire), .verdict(verdict), .mode(mode), .cur_src(cur_src),
    .fault(pll_fault)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_sel
    assign clk_sel_o[s] = (cur_src == src_e'(s));
  end

  assign mode_o = mode;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(clk_sel_o)); // R10

  AST_NOSBY_KEEPS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && mode_o == 2'd0 && !sby_en) |=> (mode_o == 2'd1 && $stable(clk_sel_o))); // R3

endmodule

// File: tb/slp_clk_ctl_test.sv
module slp_clk_ctl_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       sleep_req = 1'b0;
  logic       sby_en = 1'b0;
  logic       lson = 1'b0;
  logic [1:0] speed_mode = 2'd0;
  logic       pll_locked = 1'b1;
  logic       wake = 1'b0;
  logic [1:0] mode_o;
  logic [2:0] clk_sel_o;
  logic       pll_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [1:0] m;
    logic [2:0] s;
    logic       f;
    logic [7:0] r;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  slp_clk_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_data(rd_data), .sleep_req(sleep_req),
    .sby_en(sby_en), .lson(lson), .speed_mode(speed_mode),
    .pll_locked(pll_locked), .wake(wake), .mode_o(mode_o),
    .clk_sel_o(clk_sel_o), .pll_fault(pll_fault)
  );

  localparam logic [2:0] MAIN = 3'b001, PLL = 3'b010, SUB = 3'b100;

  task automatic tick(input string tag, input logic [1:0] m, input logic [2:0] s,
                      input logic f, input logic [7:0] r);
    exp_t e;
    @(posedge clk);
    #1;
    e.m = m; e.s = s; e.f = f; e.r = r;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    sleep_req = 1'b0;
    wake      = 1'b0;
    wr_valid  = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (mode_o !== e.m || clk_sel_o !== e.s || pll_fault !== e.f || rd_data !== e.r) begin
          errors++;
          $display("FAIL %s: actual mode=%0d sel=%b fault=%b rd=%h expected mode=%0d sel=%b fault=%b rd=%h",
                   t, mode_o, clk_sel_o, pll_fault, rd_data, e.m, e.s, e.f, e.r);
        end
        checks++;
        if ($countones(clk_sel_o) != 1) begin
          errors++;
          $display("FAIL R10: actual sel=%b expected one-hot", clk_sel_o);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick("R1 reset", 2'd0, MAIN, 1'b0, 8'h00);

    checks++;
    if (wr_ready !== 1'b1) begin
      errors++;
      $display("FAIL R2: actual wr_ready=%b expected 1", wr_ready);
    end
    wr(8'hFF);                tick("R2 reserved read 0", 2'd0, MAIN, 1'b0, 8'hE5);
    wr(8'h00);                tick("R2 clear", 2'd0, MAIN, 1'b0, 8'h00);
    wr(8'h01);                tick("R2 psel", 2'd0, MAIN, 1'b0, 8'h01);

    sby_en = 1'b0; sleep_req = 1'b1; tick("R3 plain sleep", 2'd1, MAIN, 1'b0, 8'h01);
    tick("R3 hold", 2'd1, MAIN, 1'b0, 8'h01);
    wake = 1'b1;              tick("R9 wake from sleep", 2'd0, MAIN, 1'b0, 8'h01);

    sby_en = 1'b1; sleep_req = 1'b1; tick("R4 standby", 2'd2, MAIN, 1'b0, 8'h01);
    tick("R4 pending held", 2'd2, MAIN, 1'b0, 8'h01);
    wake = 1'b1;              tick("R4 apply on wake", 2'd0, PLL, 1'b0, 8'h01);

    wr(8'h04);                tick("R5 write", 2'd0, PLL, 1'b0, 8'h04);
    sleep_req = 1'b1;         tick("R5 R6 direct to main", 2'd0, MAIN, 1'b0, 8'h04);
    wr(8'h05);                tick("R5 write2", 2'd0, MAIN, 1'b0, 8'h05);
    sleep_req = 1'b1;         tick("R6 direct to pll", 2'd0, PLL, 1'b0, 8'h05);
    lson = 1'b1; sleep_req = 1'b1; tick("R6 lson wins", 2'd0, SUB, 1'b0, 8'h05);
    lson = 1'b0;

    speed_mode = 2'd2; sleep_req = 1'b1; tick("R7 subactive standby", 2'd2, SUB, 1'b0, 8'h05);
    wake = 1'b1;              tick("R7 wake no change", 2'd0, SUB, 1'b0, 8'h05);
    speed_mode = 2'd3; sleep_req = 1'b1; tick("R7 code3 subactive", 2'd2, SUB, 1'b0, 8'h05);
    wake = 1'b1;              tick("R7 wake2", 2'd0, SUB, 1'b0, 8'h05);
    speed_mode = 2'd1; sleep_req = 1'b1; tick("R7 medium switches", 2'd0, PLL, 1'b0, 8'h05);
    speed_mode = 2'd0;

    wr(8'h04);                tick("R8 prep", 2'd0, PLL, 1'b0, 8'h04);
    sleep_req = 1'b1;         tick("R8 prep main", 2'd0, MAIN, 1'b0, 8'h04);
    wr(8'h05);                tick("R8 prep2", 2'd0, MAIN, 1'b0, 8'h05);
    pll_locked = 1'b0; sleep_req = 1'b1; tick("R8 blocked", 2'd0, MAIN, 1'b1, 8'h05);
    tick("R8 sticky", 2'd0, MAIN, 1'b1, 8'h05);
    wr(8'h05);                tick("R8 write clears", 2'd0, MAIN, 1'b0, 8'h05);
    wr(8'h05); sleep_req = 1'b1; tick("R8 set wins", 2'd0, MAIN, 1'b1, 8'h05);
    wr(8'h01);                tick("R8 clear2", 2'd0, MAIN, 1'b0, 8'h01);
    sleep_req = 1'b1;         tick("R8 standby blocked", 2'd2, MAIN, 1'b1, 8'h01);
    wake = 1'b1;              tick("R8 nothing pending", 2'd0, MAIN, 1'b1, 8'h01);
    pll_locked = 1'b1;

    wake = 1'b1;              tick("R9 wake in active", 2'd0, MAIN, 1'b1, 8'h01);
    sby_en = 1'b0; sleep_req = 1'b1; tick("R9 sleep again", 2'd1, MAIN, 1'b1, 8'h01);
    wr(8'h05);                tick("R9 write while asleep", 2'd1, MAIN, 1'b0, 8'h05);
    sby_en = 1'b1; sleep_req = 1'b1; tick("R9 sleep_req ignored", 2'd1, MAIN, 1'b0, 8'h05);
    wake = 1'b1;              tick("R9 wake", 2'd0, MAIN, 1'b0, 8'h05);

    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule